// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transceiver

This block is a byte-wide serial port that a processor reaches through a chip select, separate read and write strobes, a control/data select line and an 8-bit data path. With the select line high, a write sets the control register and a read returns a status byte. With the select line low, a write queues a byte for transmission and a read collects the last received byte. Each direction has two stages: a holding register that the processor sees, and a shift register that works on the serial line. The processor can therefore queue the next byte while the current one is still being sent, and a received byte stays available while the next one is being assembled.

Both directions are paced by bit-clock enables, `tx_tick` and `rx_tick`, each a single-cycle pulse in the system clock domain. A control field sets how many ticks make up one bit period: 1, 16 or 64. Every frame has one low start bit, eight data bits sent least significant bit first, and one high stop bit. The receiver confirms a start bit by checking the line a second time half a bit period after the falling edge. It samples every later bit in the middle of its period. It flags overrun and framing errors, and it reports a break when the line stays low for two whole frame times.

Top module: `async_serial_port`

## Requirements
- R1: While `rst` is high and in the cycle after it, `tx_rdy`=1, `tx_empty`=1, `rx_rdy`=0, `brk_det`=0 and `txd`=1. The control field resets to 1x, so the status byte reads 0x05.
- R2: An access counts only while `cs_n` is low, and it acts once, in the first cycle of the strobe. When `cd`=1, a write loads the control register and a read returns the status byte {mode[1:0], break, framing, overrun, tx_empty, rx_rdy, tx_rdy} (bit 7 down to bit 0). When `cd`=0, a write goes to the transmit holding register and a read returns the receive buffer. A write with `cs_n` high has no effect.
- R3: The transmitted frame is start 0, eight data bits LSB first, then stop 1. Each bit lasts exactly one bit period of `tx_tick` pulses, and `txd` changes only on a `tx_tick` cycle.
- R4: Control bits [1:0] select the ticks per bit: 00 gives 1, 01 gives 16, and 10 or 11 give 64. The same field paces both directions.
- R5: On a `tx_tick` where the shift register is empty, or is finishing its stop bit, a full holding register moves into the shift register. Frames therefore follow each other with no idle gap. `tx_rdy` is 1 exactly while the holding register is empty. A data write while the holding register is full is ignored.
- R6: `tx_empty` is 1 while the shift register holds no frame. It rises on the tick that ends a stop bit when no byte is waiting.
- R7: When the receiver sees a low line while idle, it checks the line again after half a bit period of `rx_tick` pulses. In 1x mode the first low sample is taken as the mid-point. If the line is high at that check, the edge is discarded and nothing is received.
- R8: Data bits and the stop bit are sampled one full bit period apart, starting from the start-bit check. After the stop sample the byte goes to the receive buffer and `rx_rdy` rises. A data read clears `rx_rdy`.
- R9: If a byte is moved to the receive buffer while `rx_rdy` is still 1, the new byte replaces the old one and the overrun status bit (bit 3) is set.
- R10: A low stop sample sets the framing status bit (bit 4). The byte is still delivered.
- R11: `brk_det` rises on the `rx_tick` that is the 2×10×(ticks per bit)-th consecutive tick with the line low, and it clears once the line is high again.
- R12: A status read clears the overrun and framing bits. The value returned by that read still shows them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high synchronous reset to idle |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cd | input | 1 | 1 selects control/status, 0 selects data |
| din | input | 8 | Write data from the processor |
| dout | output | 8 | Status byte when `cd`=1, receive buffer when `cd`=0 |
| tx_tick | input | 1 | Transmit bit-clock enable |
| rx_tick | input | 1 | Receive bit-clock enable |
| txd | output | 1 | Serial output, idles high |
| rxd | input | 1 | Serial input |
| tx_rdy | output | 1 | Transmit holding register empty |
| tx_empty | output | 1 | Transmit shift register empty |
| rx_rdy | output | 1 | Receive buffer holds an unread byte |
| brk_det | output | 1 | Line held low for two frame times |

## Verification
Register writes take effect at the clock edge inside the one-cycle strobe, so the bench checks flags at the falling edge right after the access. Reads are sampled while the strobe is still low. A transmit load and each `txd` bit change land on the `tx_tick` edge itself. The bench locates the start bit, counts half a bit period and then whole bit periods of ticks, and samples each bit at the falling clock edge after the counted tick; it checks `tx_empty` again exactly at the tick that ends the stop bit. On the receive side `rxd` passes through two synchronizing flops, which is less than the four-cycle tick spacing. Every driven bit is therefore seen at the next tick, and the stop sample, `rx_rdy` and `brk_det` are checked right after the counted tick that should produce them, with the break checked both one tick before its threshold and at it.

// File: rtl/async_serial_port.sv
module async_serial_port #(
  parameter int DATA_W     = 8,
  parameter int MULT_MAX   = 64,
  parameter int BRK_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              cd,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  input  logic              tx_tick,
  input  logic              rx_tick,
  output logic              txd,
  input  logic              rxd,
  output logic              tx_rdy,
  output logic              tx_empty,
  output logic              rx_rdy,
  output logic              brk_det
);
  localparam int FRAME  = DATA_W + 2;
  localparam int BIT_W  = $clog2(FRAME);
  localparam int DIV_W  = $clog2(MULT_MAX);
  localparam int MUL_W  = $clog2(MULT_MAX + 1);
  localparam int BRK_W  = $clog2(BRK_FRAMES * FRAME * MULT_MAX + 1);

  typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rx_state_t;

  logic [1:0]       mode;
  logic [MUL_W-1:0] mult;
  logic [DIV_W-1:0] mlast, mhalf;
  logic [BRK_W-1:0] brk_thr;

  always_comb begin
    case (mode)
      2'b00:   mult = MUL_W'(1);
      2'b01:   mult = MUL_W'(16);
      default: mult = MUL_W'(MULT_MAX);
    endcase
  end

  assign mlast   = DIV_W'(mult - MUL_W'(1));
  assign mhalf   = DIV_W'(mult >> 1);
  assign brk_thr = BRK_W'(BRK_FRAMES * FRAME) * BRK_W'(mult);

  logic wr_q, rd_q;
  wire  wr_act = !cs_n && !wr_n;
  wire  rd_act = !cs_n && !rd_n;
  wire  ctl_wr = wr_act && !wr_q && cd;
  wire  dat_wr = wr_act && !wr_q && !cd;
  wire  sts_rd = rd_act && !rd_q && cd;
  wire  dat_rd = rd_act && !rd_q && !cd;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
      mode <= 2'b00;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      if (ctl_wr) mode <= din[1:0];
    end
  end

  logic [DATA_W-1:0] thr;
  logic              thr_full;
  logic [FRAME-1:0]  tsr;
  logic              tx_busy;
  logic [BIT_W-1:0]  tbit;
  logic [DIV_W-1:0]  tdiv;

  wire tx_done = tx_tick && tx_busy && (tdiv == mlast) && (tbit == BIT_W'(FRAME - 1));
  wire tx_load = tx_tick && thr_full && (!tx_busy || tx_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      thr      <= '0;
      thr_full <= 1'b0;
      tsr      <= '1;
      tx_busy  <= 1'b0;
      tbit     <= '0;
      tdiv     <= '0;
    end else begin
      if (tx_load) begin
        tsr     <= {1'b1, thr, 1'b0};
        tx_busy <= 1'b1;
        tbit    <= '0;
        tdiv    <= '0;
      end else if (tx_done) begin
        tx_busy <= 1'b0;
      end else if (tx_tick && tx_busy) begin
        if (tdiv == mlast) begin
          tdiv <= '0;
          tbit <= tbit + BIT_W'(1);
          tsr  <= {1'b1, tsr[FRAME-1:1]};
        end else begin
          tdiv <= tdiv + DIV_W'(1);
        end
      end
      if (tx_load) begin
        thr_full <= 1'b0;
      end else if (dat_wr && !thr_full) begin
        thr      <= din;
        thr_full <= 1'b1;
      end
    end
  end

  assign txd      = tx_busy ? tsr[0] : 1'b1;
  assign tx_rdy   = !thr_full;
  assign tx_empty = !tx_busy;

  logic [1:0]        rsync;
  wire               rxs = rsync[1];
  rx_state_t         rstate;
  logic [DIV_W-1:0]  rdiv;
  logic [BIT_W-1:0]  rbit;
  logic [DATA_W-1:0] rsr, rbr;
  logic              rx_full, oe, fe;
  logic [BRK_W-1:0]  bcnt;

  wire rsamp  = rdiv == mlast;
  wire rx_fin = rx_tick && (rstate == R_STOP) && rsamp;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsync  <= 2'b11;
      rstate <= R_IDLE;
      rdiv   <= '0;
      rbit   <= '0;
      rsr    <= '0;
    end else begin
      rsync <= {rsync[0], rxd};
      if (rx_tick) begin
        case (rstate)
          R_IDLE: if (!rxs) begin
            rdiv   <= '0;
            rbit   <= '0;
            rstate <= (mhalf == '0) ? R_DATA : R_START;
          end
          R_START: if (rdiv == mhalf - DIV_W'(1)) begin
            rdiv   <= '0;
            rstate <= rxs ? R_IDLE : R_DATA;
          end else begin
            rdiv <= rdiv + DIV_W'(1);
          end
          R_DATA: if (rsamp) begin
            rdiv <= '0;
            rsr  <= {rxs, rsr[DATA_W-1:1]};
            if (rbit == BIT_W'(DATA_W - 1)) rstate <= R_STOP;
            else                            rbit   <= rbit + BIT_W'(1);
          end else begin
            rdiv <= rdiv + DIV_W'(1);
          end
          default: if (rsamp) begin
            rdiv   <= '0;
            rstate <= R_IDLE;
          end else begin
            rdiv <= rdiv + DIV_W'(1);
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rbr     <= '0;
      rx_full <= 1'b0;
      oe      <= 1'b0;
      fe      <= 1'b0;
    end else begin
      if (dat_rd) rx_full <= 1'b0;
      if (sts_rd) begin
        oe <= 1'b0;
        fe <= 1'b0;
      end
      if (rx_fin) begin
        rbr     <= rsr;
        rx_full <= 1'b1;
        if (rx_full && !dat_rd) oe <= 1'b1;
        if (!rxs)               fe <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || rxs)                      bcnt <= '0;
    else if (rx_tick && bcnt < brk_thr)  bcnt <= bcnt + BRK_W'(1);
  end

  assign brk_det = (bcnt >= brk_thr);
  assign rx_rdy  = rx_full;

  wire [7:0] status = {mode, brk_det, fe, oe, tx_empty, rx_full, tx_rdy};
  assign dout = cd ? DATA_W'(status) : rbr;

endmodule

// File: rtl/async_serial_port_chk.sv
module async_serial_port_chk (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic rd_n,
  input logic wr_n,
  input logic cd,
  input logic tx_tick,
  input logic rx_tick,
  input logic txd,
  input logic tx_rdy,
  input logic tx_empty,
  input logic rx_rdy,
  input logic brk_det
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (tx_rdy && tx_empty && !rx_rdy && !brk_det && txd));

  a_r5_txrdy_falls_on_write: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_rdy) |-> $past(!cs_n && !wr_n && !cd));

  a_r3_txd_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
    !$stable(txd) |-> $past(tx_tick));

  a_r6_txempty_rises_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_empty) |-> $past(tx_tick));

  a_r8_rxrdy_rises_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_rdy) |-> $past(rx_tick));

  a_r8_rxrdy_falls_on_read: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_rdy) |-> $past(!cs_n && !rd_n && !cd));

  a_r11_break_rises_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(brk_det) |-> ($past(rx_tick) || $past(!cs_n && !wr_n && cd)));
endmodule

bind async_serial_port async_serial_port_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .cd(cd),
  .tx_tick(tx_tick), .rx_tick(rx_tick), .txd(txd), .tx_rdy(tx_rdy),
  .tx_empty(tx_empty), .rx_rdy(rx_rdy), .brk_det(brk_det)
);

// File: tb/tb_async_serial_port.sv
`timescale 1ns/1ps
module tb_async_serial_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cd = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic       tick = 1'b0;
  logic [1:0] tcnt = 2'd0;
  logic       txd, rx_drv = 1'b1;
  logic       tx_rdy, tx_empty, rx_rdy, brk_det;
  int         nchk = 0, nerr = 0;
  int         mult = 1;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tcnt <= tcnt + 2'd1;
    tick <= (tcnt == 2'd3);
  end

  async_serial_port dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .cd(cd),
    .din(din), .dout(dout), .tx_tick(tick), .rx_tick(tick), .txd(txd),
    .rxd(rx_drv), .tx_rdy(tx_rdy), .tx_empty(tx_empty), .rx_rdy(rx_rdy),
    .brk_det(brk_det)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_tick();
    do @(posedge clk); while (!tick);
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) wait_tick();
  endtask

  task automatic bus_write(input logic sel, input logic [7:0] v, input logic chip = 1'b1);
    @(negedge clk);
    cs_n = !chip; wr_n = 1'b0; cd = sel; din = v;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_read(input logic sel, output logic [7:0] v);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; cd = sel;
    #2 v = dout;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic set_mode(input logic [1:0] m);
    bus_write(1'b1, {6'd0, m});
    mult = (m == 2'b00) ? 1 : (m == 2'b01) ? 16 : 64;
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop);
    logic [9:0] f;
    f = {stop, b, 1'b0};
    wait_tick();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk) rx_drv = f[i];
      wait_ticks(mult);
    end
    @(negedge clk) rx_drv = 1'b1;
  endtask

  task automatic capture(output logic [7:0] b, output logic st, output logic sp);
    int h;
    h = mult / 2;
    while (txd) @(negedge clk);
    wait_ticks(h);
    if (h > 0) @(negedge clk);
    st = txd;
    for (int i = 0; i < 8; i++) begin
      wait_ticks(mult);
      @(negedge clk);
      b[i] = txd;
    end
    wait_ticks(mult);
    @(negedge clk);
    sp = txd;
  endtask

  task automatic tx_one(input string tag, input logic [7:0] v);
    logic [7:0] b;
    logic st, sp;
    fork
      capture(b, st, sp);
      bus_write(1'b0, v);
    join
    chk({tag, " start bit"}, st, 0);
    chk({tag, " data"}, b, v);
    chk({tag, " stop bit"}, sp, 1);
    chk("R6 tx_empty low during stop", tx_empty, 0);
    wait_ticks(mult - mult / 2);
    @(negedge clk);
    chk("R6 tx_empty at end of stop", tx_empty, 1);
  endtask

  task automatic rx_one(input string tag, input logic [7:0] v, input logic [7:0] sts);
    logic [7:0] r;
    send_frame(v, 1'b1);
    chk({tag, " rx_rdy port"}, rx_rdy, 1);
    bus_read(1'b1, r);
    chk({tag, " status"}, r, sts);
    bus_read(1'b0, r);
    chk({tag, " data"}, r, v);
    chk("R8 rx_rdy cleared by data read", rx_rdy, 0);
  endtask

  task automatic test_reset();
    logic [7:0] r;
    chk("R1 tx_rdy", tx_rdy, 1);
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 rx_rdy", rx_rdy, 0);
    chk("R1 brk_det", brk_det, 0);
    chk("R1 txd", txd, 1);
    bus_read(1'b1, r);
    chk("R1 status", r, 8'h05);
  endtask

  task automatic test_decode();
    logic [7:0] r;
    bus_write(1'b0, 8'hAA, 1'b0);
    wait_ticks(8);
    @(negedge clk);
    chk("R2 unselected write tx_rdy", tx_rdy, 1);
    chk("R2 unselected write tx_empty", tx_empty, 1);
    chk("R2 unselected write txd", txd, 1);
    set_mode(2'b01);
    bus_read(1'b1, r);
    chk("R2 R4 control write reflected in status", r, 8'h45);
  endtask

  task automatic test_double_buffer();
    logic [7:0] b0, b1;
    logic s0, p0, s1, p1;
    int lows;
    fork
      begin
        capture(b0, s0, p0);
        capture(b1, s1, p1);
      end
      begin
        bus_write(1'b0, 8'h11);
        chk("R5 tx_rdy low after write", tx_rdy, 0);
        chk("R6 tx_empty before load", tx_empty, 1);
        wait_tick();
        @(negedge clk);
        chk("R5 tx_rdy high after load", tx_rdy, 1);
        chk("R6 tx_empty low after load", tx_empty, 0);
        bus_write(1'b0, 8'h22);
        chk("R5 tx_rdy low second byte", tx_rdy, 0);
        bus_write(1'b0, 8'h33);
      end
    join
    chk("R5 first frame", b0, 8'h11);
    chk("R5 second frame", b1, 8'h22);
    chk("R3 framing of back-to-back", {s0, p0, s1, p1}, 4'b0101);
    wait_ticks(mult - mult / 2);
    @(negedge clk);
    chk("R6 tx_empty after second frame", tx_empty, 1);
    lows = 0;
    for (int i = 0; i < 10 * mult; i++) begin
      wait_tick();
      @(negedge clk);
      if (!txd) lows++;
    end
    chk("R5 write while full ignored", lows, 0);
  endtask

  task automatic test_false_start();
    logic [7:0] r;
    wait_tick();
    @(negedge clk) rx_drv = 1'b0;
    wait_ticks(mult / 2 - 4);
    @(negedge clk) rx_drv = 1'b1;
    wait_ticks(20 * mult);
    @(negedge clk);
    chk("R7 short pulse not received", rx_rdy, 0);
    bus_read(1'b1, r);
    chk("R7 status after short pulse", r, 8'h45);
    rx_one("R7 frame after false start", 8'h4B, 8'h47);
  endtask

  task automatic test_overrun();
    logic [7:0] r;
    send_frame(8'h12, 1'b1);
    send_frame(8'h34, 1'b1);
    bus_read(1'b1, r);
    chk("R9 overrun status", r, 8'h4F);
    bus_read(1'b0, r);
    chk("R9 newer byte kept", r, 8'h34);
    bus_read(1'b1, r);
    chk("R12 overrun cleared by status read", r, 8'h45);
  endtask

  task automatic test_framing();
    logic [7:0] r;
    send_frame(8'h55, 1'b0);
    wait_ticks(2 * mult);
    @(negedge clk);
    bus_read(1'b1, r);
    chk("R10 framing status", r, 8'h57);
    bus_read(1'b0, r);
    chk("R10 data still delivered", r, 8'h55);
    bus_read(1'b1, r);
    chk("R12 framing cleared by status read", r, 8'h45);
  endtask

  task automatic test_modes();
    set_mode(2'b00);
    tx_one("R4 1x tx", 8'h3C);
    rx_one("R4 1x rx", 8'hE1, 8'h07);
    set_mode(2'b10);
    tx_one("R4 64x tx", 8'hC3);
    rx_one("R4 64x rx", 8'h5A, 8'h87);
    set_mode(2'b01);
  endtask

  task automatic test_break();
    logic [7:0] r;
    int thr;
    thr = 2 * 10 * mult;
    wait_tick();
    @(negedge clk) rx_drv = 1'b0;
    wait_ticks(thr - 1);
    @(negedge clk);
    chk("R11 no break one tick early", brk_det, 0);
    wait_tick();
    @(negedge clk);
    chk("R11 break at threshold", brk_det, 1);
    bus_read(1'b1, r);
    chk("R11 break status bit", r[5], 1);
    chk("R10 framing seen during break", r[4], 1);
    rx_drv = 1'b1;
    wait_ticks(2);
    @(negedge clk);
    chk("R11 break clears when line high", brk_det, 0);
    wait_ticks(25 * mult);
    bus_read(1'b0, r);
    bus_read(1'b1, r);
    bus_read(1'b1, r);
    chk("R11 idle status after break", r, 8'h45);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    test_reset();
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_decode();
    tx_one("R3 16x tx", 8'hA5);
    test_double_buffer();
    rx_one("R8 rx pattern 96", 8'h96, 8'h47);
    rx_one("R8 rx pattern 01", 8'h01, 8'h47);
    rx_one("R8 rx pattern 80", 8'h80, 8'h47);
    test_false_start();
    test_overrun();
    test_framing();
    test_modes();
    test_break();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule